// File: doc/BRIEF.md
# Masked Interrupt Request Summary

This block gathers nineteen level-sensitive interrupt request lines (four pins from each of four add-in slots and three on-board devices) and presents them as three byte-wide registers on a simple 8-bit host I/O bus. The three registers sit at consecutive byte addresses starting at a base address. Reads and writes at the same address reach different storage. A read returns the live, unmasked level of the request lines. A write loads a byte of a mask that software can never read back.

A mask bit of 1 disables its source. Reset sets every mask bit, so no source can interrupt the processor until software clears bits. Every request line is brought into the clock domain through two flip-flops before it is used. The block drives a single combined request to the processor. That request is high while any synchronized line is both active and enabled, and it holds no state of its own. The block also reports the index of the lowest-numbered pending, enabled source, so a handler can service sources in ascending order.

Source numbering: source i is bit i of `irq_req_i` and appears at register byte i/8, bit i%8. Byte 0 holds the A pins of slots 0 to 3 in bits 0 to 3, the I/O bridge in bit 4, IDE in bit 5, USB in bit 6 and slot 0 pin B in bit 7. Byte 1 holds the B pins of slots 1 to 3, the C pins of slots 0 to 3 and slot 0 pin D. Byte 2 holds the D pins of slots 1 to 3 in bits 0 to 2.

Top module: `irq_summary_top`

## Requirements
- R1: After reset all nineteen mask bits are 1. With every request line high, `irq_o` stays 0 and `pend_valid_o` stays 0 until software writes the mask.
- R2: A write with `bus_wr_i` high at address BASE+k (k = 0, 1, 2) loads byte k of the mask from `bus_wdata_i` at the next clock edge. A mask bit of 1 disables the source with the same number and a 0 enables it. Mask bits that do not exist (byte 2, bits 7 to 3) are dropped.
- R3: A read with `bus_rd_i` high at address BASE+k returns, one clock later on `bus_rdata_o`, the synchronized request levels for byte k, with source i at byte i/8 bit i%8. Bits 7 to 3 of byte 2 read as 0.
- R4: Read data never reflects the mask. A byte read after any mask write equals the raw request levels.
- R5: `irq_o` is 1 exactly while some synchronized request is 1 and its mask bit is 0. No latching is done, so `irq_o` falls once no such source remains.
- R6: When `pend_valid_o` is 1, `pend_idx_o` is the lowest source number that is both requesting and enabled. When no source qualifies, `pend_valid_o` is 0 and `pend_idx_o` is 0.
- R7: A change on a request line first affects `irq_o`, the pending outputs and read data after exactly two rising clock edges.
- R8: Accesses outside BASE to BASE+2 have no effect: a write there leaves the mask unchanged, and a read there returns 0.
- R9: `rst_n` asserts asynchronously and is released synchronously. A reset in the middle of operation restores the all-ones mask.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr_i | input | 12 | I/O byte address |
| bus_wr_i | input | 1 | Write strobe, one cycle per write |
| bus_wdata_i | input | 8 | Write data |
| bus_rd_i | input | 1 | Read strobe, one cycle per read |
| bus_rdata_o | output | 8 | Read data, valid the cycle after the strobe |
| irq_req_i | input | 19 | Asynchronous level request lines, source i at bit i |
| irq_o | output | 1 | Combined request to the processor |
| pend_idx_o | output | 5 | Lowest pending enabled source number |
| pend_valid_o | output | 1 | A pending enabled source exists |

## Verification
The bench targets the split between read and write paths. It reads a register right after loading a conflicting mask: a design that returned the mask, or the masked levels, would give the wrong byte. It times a request edge cycle by cycle. This would expose a synchronizer that is one stage short or one stage long, and an output that latched and stayed high after the line fell. It also drives several sources together at the two ends of the numbering, writes to addresses just outside the window, and resets in the middle of operation. These catch a priority encoder that picks the highest source, an address decode that is off by one, and a mask that does not return to all ones.

// File: rtl/irq_summary_pkg.sv
package irq_summary_pkg;
  localparam int unsigned SRC_CNT    = 19;
  localparam int unsigned LANE_BITS  = 8;
  localparam int unsigned ADDR_BITS  = 12;
  localparam logic [ADDR_BITS-1:0] BASE_DEFAULT = 12'h804;

  function automatic int unsigned lanes_for(input int unsigned n);
    return (n + LANE_BITS - 1) / LANE_BITS;
  endfunction
endpackage

// File: rtl/irq_rst_sync.sv
module irq_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);
  logic [1:0] chain_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= 2'b00;
    else        chain_q <= {chain_q[0], 1'b1};
  end

  assign rst_n_sync = chain_q[1];
endmodule

// File: rtl/irq_in_sync.sv
module irq_in_sync #(
  parameter int unsigned WIDTH = 19
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] async_i,
  output logic [WIDTH-1:0] sync_o
);
  logic [WIDTH-1:0] meta_q;
  logic [WIDTH-1:0] stab_q;

  for (genvar g = 0; g < WIDTH; g++) begin : g_bit
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        meta_q[g] <= 1'b0;
        stab_q[g] <= 1'b0;
      end else begin
        meta_q[g] <= async_i[g];
        stab_q[g] <= meta_q[g];
      end
    end

    // R7: a rising output bit was high on the input two edges earlier
    a_r7_two_stage: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(stab_q[g]) |-> $past(async_i[g], 2));
  end

  assign sync_o = stab_q;
endmodule

// File: rtl/irq_addr_decode.sv
module irq_addr_decode #(
  parameter int unsigned ADDR_W = 12,
  parameter logic [ADDR_W-1:0] BASE = 12'h804,
  parameter int unsigned LANES  = 3,
  localparam int unsigned LANE_W = (LANES > 1) ? $clog2(LANES) : 1
) (
  input  logic [ADDR_W-1:0] addr_i,
  output logic              hit_o,
  output logic [LANE_W-1:0] lane_o
);
  localparam logic [ADDR_W-1:0] LANES_A = ADDR_W'(LANES);
  logic [ADDR_W-1:0] offset;

  always_comb begin
    offset = addr_i - BASE;
    hit_o  = (addr_i >= BASE) && (offset < LANES_A);
    lane_o = offset[LANE_W-1:0];
  end
endmodule

// File: rtl/irq_mask_reg.sv
module irq_mask_reg #(
  parameter int unsigned NSRC   = 19,
  parameter int unsigned LANE_B = 8,
  parameter int unsigned LANES  = 3,
  localparam int unsigned LANE_W = (LANES > 1) ? $clog2(LANES) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_i,
  input  logic [LANE_W-1:0] lane_i,
  input  logic [LANE_B-1:0] wdata_i,
  output logic [NSRC-1:0]   mask_o
);
  logic [NSRC-1:0]  mask_q;
  logic [NSRC-1:0]  mask_d;
  logic [LANES-1:0] lane_we;

  for (genvar l = 0; l < LANES; l++) begin : g_lane
    assign lane_we[l] = wr_i && (lane_i == LANE_W'(l));
  end

  for (genvar s = 0; s < NSRC; s++) begin : g_src
    localparam int unsigned LN = s / LANE_B;
    localparam int unsigned BT = s % LANE_B;
    always_comb begin
      mask_d[s] = mask_q[s];
      if (lane_we[LN]) mask_d[s] = wdata_i[BT];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) mask_q <= '1;
    else        mask_q <= mask_d;
  end

  assign mask_o = mask_q;

  // R2: without a write the mask holds its value
  a_r2_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_i |=> $stable(mask_q));
  // R2: a write to lane 0 loads that lane's bits from the data bus
  a_r2_lane0_load: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_i && lane_i == '0) |=> mask_q[LANE_B-1:0] == $past(wdata_i));
endmodule

// File: rtl/irq_prio_enc.sv
module irq_prio_enc #(
  parameter int unsigned NSRC  = 19,
  localparam int unsigned IDX_W = $clog2(NSRC)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NSRC-1:0]  req_i,
  output logic [IDX_W-1:0] idx_o,
  output logic             valid_o
);
  always_comb begin
    idx_o   = '0;
    valid_o = 1'b0;
    for (int i = NSRC - 1; i >= 0; i--) begin
      if (req_i[i]) begin
        idx_o   = IDX_W'(i);
        valid_o = 1'b1;
      end
    end
  end

  // R6: reported source is requesting
  a_r6_idx_live: assert property (@(posedge clk) disable iff (!rst_n)
    valid_o |-> req_i[idx_o]);
  // R6: nothing below the reported source is requesting
  a_r6_lowest: assert property (@(posedge clk) disable iff (!rst_n)
    valid_o |-> ((req_i & ((NSRC'(1) << idx_o) - NSRC'(1))) == '0));
  // R6: no valid flag means no request and index zero
  a_r6_none: assert property (@(posedge clk) disable iff (!rst_n)
    !valid_o |-> (req_i == '0 && idx_o == '0));
endmodule

// File: rtl/irq_summary_top.sv
module irq_summary_top
  import irq_summary_pkg::*;
#(
  parameter int unsigned NSRC   = SRC_CNT,
  parameter int unsigned ADDR_W = ADDR_BITS,
  parameter logic [ADDR_W-1:0] BASE = BASE_DEFAULT,
  localparam int unsigned LANES  = lanes_for(NSRC),
  localparam int unsigned LANE_W = (LANES > 1) ? $clog2(LANES) : 1,
  localparam int unsigned IDX_W  = $clog2(NSRC),
  localparam int unsigned PAD_W  = LANES * LANE_BITS
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [ADDR_W-1:0]    bus_addr_i,
  input  logic                 bus_wr_i,
  input  logic [LANE_BITS-1:0] bus_wdata_i,
  input  logic                 bus_rd_i,
  output logic [LANE_BITS-1:0] bus_rdata_o,
  input  logic [NSRC-1:0]      irq_req_i,
  output logic                 irq_o,
  output logic [IDX_W-1:0]     pend_idx_o,
  output logic                 pend_valid_o
);
  logic              rst_n_s;
  logic              hit;
  logic [LANE_W-1:0] lane;
  logic [NSRC-1:0]   req_sync;
  logic [NSRC-1:0]   mask;
  logic [NSRC-1:0]   live;
  logic [PAD_W-1:0]  raw_pad;
  logic [LANE_BITS-1:0] rdata_q;
  logic [LANE_BITS-1:0] rdata_d;
  logic              rd_cap_en;

  irq_rst_sync u_rst (.clk(clk), .rst_n(rst_n), .rst_n_sync(rst_n_s));

  irq_in_sync #(.WIDTH(NSRC)) u_sync (
    .clk(clk), .rst_n(rst_n_s), .async_i(irq_req_i), .sync_o(req_sync));

  irq_addr_decode #(.ADDR_W(ADDR_W), .BASE(BASE), .LANES(LANES)) u_dec (
    .addr_i(bus_addr_i), .hit_o(hit), .lane_o(lane));

  irq_mask_reg #(.NSRC(NSRC), .LANE_B(LANE_BITS), .LANES(LANES)) u_mask (
    .clk(clk), .rst_n(rst_n_s), .wr_i(bus_wr_i && hit), .lane_i(lane),
    .wdata_i(bus_wdata_i), .mask_o(mask));

  assign live = req_sync & ~mask;

  irq_prio_enc #(.NSRC(NSRC)) u_prio (
    .clk(clk), .rst_n(rst_n_s), .req_i(live),
    .idx_o(pend_idx_o), .valid_o(pend_valid_o));

  assign irq_o = |live;

  // read path: raw levels, zero padded, captured on a read strobe
  always_comb begin
    raw_pad   = PAD_W'(req_sync);
    rd_cap_en = bus_rd_i;
    rdata_d   = '0;
    if (hit) rdata_d = raw_pad[lane*LANE_BITS +: LANE_BITS];
  end

  always_ff @(posedge clk or negedge rst_n_s) begin
    if (!rst_n_s)       rdata_q <= '0;
    else if (rd_cap_en) rdata_q <= rdata_d;
  end

  assign bus_rdata_o = rdata_q;

  // R8: a read outside the window returns zero
  a_r8_unmapped_read: assert property (@(posedge clk) disable iff (!rst_n_s)
    (bus_rd_i && !hit) |=> bus_rdata_o == '0);
  // R1: mask comes out of reset fully set, so no request is forwarded
  a_r1_quiet_after_reset: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n_s) |-> !irq_o);
  // R5: output follows the pending flag with no extra state
  a_r5_out_vs_pend: assert property (@(posedge clk) disable iff (!rst_n_s)
    irq_o == pend_valid_o);
  // R3: reserved top bits of the last lane read back as zero
  a_r3_reserved_zero: assert property (@(posedge clk) disable iff (!rst_n_s)
    (bus_rd_i && hit && lane == LANE_W'(LANES-1)) |=>
      (bus_rdata_o >> (NSRC - (LANES-1)*LANE_BITS)) == '0);
endmodule

// File: tb/irq_summary_top_tb.sv
module irq_summary_top_tb;
  localparam int NS = 19;
  localparam logic [11:0] BASE = 12'h804;

  logic clk = 1'b0;
  logic rst_n;
  logic [11:0] addr;
  logic wr, rd;
  logic [7:0] wdata, rdata;
  logic [NS-1:0] lines;
  logic irq;
  logic [4:0] pidx;
  logic pval;

  int checks = 0;
  int fails  = 0;
  logic [NS-1:0] bm;
  logic rd_seen;

  typedef struct { logic [7:0] exp; string tag; } rd_item_t;
  rd_item_t rq[$];

  always #5 clk = ~clk;

  irq_summary_top u_dut (
    .clk(clk), .rst_n(rst_n), .bus_addr_i(addr), .bus_wr_i(wr),
    .bus_wdata_i(wdata), .bus_rd_i(rd), .bus_rdata_o(rdata),
    .irq_req_i(lines), .irq_o(irq), .pend_idx_o(pidx), .pend_valid_o(pval));

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  always @(posedge clk) rd_seen <= rd;

  // monitor: pops expected read data the cycle after each strobe
  always @(negedge clk) begin
    if (rd_seen === 1'b1) begin
      if (rq.size() == 0) begin
        checks++; fails++;
        $display("FAIL scoreboard actual=unexpected_read expected=none");
      end else begin
        rd_item_t it;
        it = rq.pop_front();
        check(it.tag, {24'h0, rdata}, {24'h0, it.exp});
      end
    end
  end

  task automatic bus_write(input logic [11:0] a, input logic [7:0] d);
    @(negedge clk);
    addr = a; wdata = d; wr = 1'b1;
    if (a >= BASE && a < BASE + 12'd3)
      for (int b = 0; b < 8; b++) begin
        int s;
        s = int'(a - BASE) * 8 + b;
        if (s < NS) bm[s] = d[b];
      end
    @(negedge clk);
    wr = 1'b0;
  endtask

  task automatic bus_read(input logic [11:0] a, input string tag);
    rd_item_t it;
    logic [23:0] pad;
    @(negedge clk);
    pad = 24'(lines);
    it.tag = tag;
    it.exp = (a >= BASE && a < BASE + 12'd3) ? pad[int'(a - BASE)*8 +: 8] : 8'h00;
    rq.push_back(it);
    addr = a; rd = 1'b1;
    @(negedge clk);
    rd = 1'b0;
  endtask

  task automatic settle();
    repeat (3) @(negedge clk);
  endtask

  task automatic check_out(input string tag);
    logic [NS-1:0] l;
    int idx;
    l = lines & ~bm;
    idx = 0;
    for (int i = NS - 1; i >= 0; i--) if (l[i]) idx = i;
    check({tag, " irq"}, {31'h0, irq}, {31'h0, |l});
    check({tag, " valid"}, {31'h0, pval}, {31'h0, |l});
    check({tag, " idx"}, {27'h0, pidx}, 32'(idx));
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    bm = '1;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
  endtask

  initial begin
    rst_n = 1'b0; addr = '0; wr = 1'b0; rd = 1'b0; wdata = '0;
    lines = '1; bm = '1;
    do_reset();

    check_out("R1 reset mask all ones");
    bus_read(BASE,          "R3 byte0 raw");
    bus_read(BASE + 12'd1,  "R3 byte1 raw");
    bus_read(BASE + 12'd2,  "R3 byte2 raw reserved zero");

    bus_write(BASE + 12'd3, 8'h00);
    bus_write(BASE - 12'd1, 8'h00);
    @(negedge clk);
    check_out("R8 unmapped write ignored");
    bus_read(BASE + 12'd3, "R8 read above window");
    bus_read(BASE - 12'd1, "R8 read below window");

    bus_write(BASE + 12'd1, 8'hEF);
    @(negedge clk);
    check_out("R2 enable source 12");
    bus_read(BASE + 12'd1, "R4 read is raw not mask");

    bus_write(BASE, 8'hF7);
    @(negedge clk);
    check_out("R6 lowest of 3 and 12");
    bus_read(BASE, "R4 read after mask write");

    @(negedge clk);
    lines = 19'(1) << 12;
    settle();
    check_out("R6 only 12");

    // R7 / R5: exact two-edge latency and no latching on fall
    lines = '0;
    @(negedge clk);
    check("R7 one edge still high", {31'h0, irq}, 32'd1);
    @(negedge clk);
    check("R5 R7 falls after two edges", {31'h0, irq}, 32'd0);
    lines = 19'(1) << 12;
    @(negedge clk);
    check("R7 one edge still low", {31'h0, irq}, 32'd0);
    @(negedge clk);
    check("R7 rises after two edges", {31'h0, irq}, 32'd1);

    bus_write(BASE,          8'h00);
    bus_write(BASE + 12'd1,  8'h00);
    bus_write(BASE + 12'd2,  8'h00);
    lines = 19'(1) << 18;
    settle();
    check_out("R6 top source 18");
    bus_read(BASE + 12'd2, "R3 source 18 at byte2 bit2");
    lines = (19'(1) << 18) | 19'(1);
    settle();
    check_out("R6 source 0 beats 18");

    lines = 19'(1) << 18;
    bus_write(BASE + 12'd2, 8'hFF);
    settle();
    check_out("R2 mask source 18");
    bus_write(BASE + 12'd2, 8'hF8);
    settle();
    check_out("R2 reserved bits dropped, 18 enabled");

    lines = 19'h5A3C1;
    bus_write(BASE, 8'hC0);
    settle();
    check_out("R6 mixed pattern");
    bus_read(BASE,          "R3 mixed byte0");
    bus_read(BASE + 12'd1,  "R3 mixed byte1");
    bus_read(BASE + 12'd2,  "R3 mixed byte2");

    lines = '1;
    settle();
    check_out("R5 enabled with all lines");
    do_reset();
    check_out("R9 mid-run reset restores mask");
    bus_read(BASE + 12'd2, "R9 read after reset");

    repeat (3) @(negedge clk);
    if (rq.size() != 0) begin
      checks++; fails++;
      $display("FAIL scoreboard actual=%0d expected=0 pending reads", rq.size());
    end
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule